// File: doc/BRIEF.md
# Isolation Unlock Sequence Detector

This block guards the path from a register bus into an always-on domain. Software writes 3-bit codes into a control field. The detector accepts them only when they arrive in one fixed order. For each accepted step it reports progress through an acknowledge bit, whose value alternates with the parity of the step index. Software polls that bit before it writes the next code.

When the last step of the order has been accepted, a programmable delay runs. After it, an isolation-enable flag is held high for a programmable number of cycles. The always-on side uses that window to latch whatever transfer is pending. When the window closes, the detector goes back to waiting for a new sequence from the first step. A code that breaks the order restarts the detection, and a repeated code is simply absorbed.

Top module: `iso_unlock_seq`

## Requirements
- R1: A synchronous active-low reset clears the step progress, the acknowledge bit and the enable flag. All three read 0 on the first cycle after a reset edge.
- R2: Only bits [2:0] of a control write form the code. Bits [7:3] of the write data have no effect on the outputs.
- R3: When step i (counting from 0) is accepted, the acknowledge bit reads i mod 2 from the cycle after the write. It sits at bit 3 of the acknowledge status word.
- R4: The codes are accepted only in this order: 0, 1, 3, 7, 5, 1, 0 (seven steps).
- R5: A code that is neither the expected next code nor a repeat of the last accepted code restarts detection and forces the acknowledge bit to 0. If that code is 0, it is taken as step 0, so the next expected code is 1.
- R6: Writing again the code that was last accepted changes neither the progress nor the acknowledge bit.
- R7: The enable flag rises exactly EN_LAG cycles after the clock edge that accepts the seventh step. It stays high for exactly PULSE_LEN cycles. It appears both on `iso_en_o` and at bit 0 of the isolation status word.
- R8: Control writes made between acceptance of the seventh step and the end of the enable pulse are ignored.
- R9: After the enable pulse ends, the detector is back at step 0 with the acknowledge bit 0, and a new complete sequence produces a new pulse.
- R10: All bits of the two status words other than the acknowledge bit and the enable bit read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr_en_i | input | 1 | Control write strobe, one cycle per write |
| ctl_wr_data_i | input | DATA_W | Control write data; only bits [2:0] form the code |
| ack_stat_o | output | DATA_W | Acknowledge status word; bit 3 is the acknowledge bit |
| iso_stat_o | output | DATA_W | Isolation status word; bit 0 is the enable flag |
| iso_en_o | output | 1 | Enable flag for the always-on domain |

## Verification
The hardest states to reach from the ports are the ones where the restart rule and the repeat rule meet. One example is a stray 0 written after step 1: it must land on step 0 and not on an empty state. Another is a repeated 1 at step 5, whose code also appears at step 1. The stimulus reaches these by writing deliberately broken and stuttered sequences that still finish correctly, so a wrong restart target or a wrong repeat rule shows up as a missing or extra enable pulse. Writes are also injected during the delay and during the pulse, and a reset is applied in the middle of a sequence. A behavioural model then checks every cycle.

// File: rtl/iso_unlock_pkg.sv
// Shared definitions for the isolation unlock detector.
// Assumes: the unlock order is fixed at seven codes of three bits each.
package iso_unlock_pkg;

    localparam int SEQ_LEN = 7;
    localparam int CODE_W  = 3;
    localparam int STEP_W  = $clog2(SEQ_LEN + 1);

    // Classification of one control write against the current progress.
    typedef enum logic [1:0] {
        MK_HOLD          = 2'd0,
        MK_ADVANCE       = 2'd1,
        MK_RESTART_EMPTY = 2'd2,
        MK_RESTART_FIRST = 2'd3
    } match_kind_t;

    // Phase of the enable timer.
    typedef enum logic [1:0] {
        PH_COLLECT = 2'd0,
        PH_ARM     = 2'd1,
        PH_PULSE   = 2'd2
    } phase_t;

    // Code expected at a given step index of the unlock order.
    function automatic logic [CODE_W-1:0] step_code(input logic [STEP_W-1:0] idx);
        case (idx)
            STEP_W'(0): step_code = CODE_W'(3'h0);
            STEP_W'(1): step_code = CODE_W'(3'h1);
            STEP_W'(2): step_code = CODE_W'(3'h3);
            STEP_W'(3): step_code = CODE_W'(3'h7);
            STEP_W'(4): step_code = CODE_W'(3'h5);
            STEP_W'(5): step_code = CODE_W'(3'h1);
            default:    step_code = CODE_W'(3'h0);
        endcase
    endfunction

endpackage

// File: rtl/iso_code_match.sv
// Classifies an incoming code against the number of steps accepted so far.
// Purely combinational. Assumes accepted < SEQ_LEN whenever the result is used.
module iso_code_match
    import iso_unlock_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic [STEP_W-1:0] accepted_i,
    output match_kind_t       kind_o,
    output logic              is_last_o
);

    logic [CODE_W-1:0] expected_code;
    logic [CODE_W-1:0] prior_code;
    logic              has_prior;

    // Look up the next expected code and the code that was last accepted.
    always_comb begin
        expected_code = step_code(accepted_i);
        prior_code    = step_code(accepted_i - STEP_W'(1));
        has_prior     = (accepted_i != '0);
    end

    // Decide: repeat, advance, or restart (onto step 0 or onto nothing).
    always_comb begin
        if (has_prior && (code_i == prior_code)) begin
            kind_o = MK_HOLD;
        end else if (code_i == expected_code) begin
            kind_o = MK_ADVANCE;
        end else if (code_i == step_code('0)) begin
            kind_o = MK_RESTART_FIRST;
        end else begin
            kind_o = MK_RESTART_EMPTY;
        end
    end

    // Flag the final step of the order.
    always_comb begin
        is_last_o = (accepted_i == STEP_W'(SEQ_LEN - 1));
    end

endmodule

// File: rtl/iso_step_tracker.sv
// Holds the step progress and the parity acknowledge bit.
// Assumes fire_i is low while the enable timer is busy, and clear_i pulses once when the timer finishes.
module iso_step_tracker
    import iso_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  match_kind_t       kind_i,
    input  logic              is_last_i,
    input  logic              clear_i,
    output logic [STEP_W-1:0] accepted_o,
    output logic              ack_o,
    output logic              seq_done_o
);

    // Update progress and acknowledge on each qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            accepted_o <= '0;
            ack_o      <= 1'b0;
        end else if (fire_i) begin
            case (kind_i)
                MK_ADVANCE: begin
                    ack_o      <= accepted_o[0];
                    accepted_o <= accepted_o + STEP_W'(1);
                end
                MK_RESTART_FIRST: begin
                    ack_o      <= 1'b0;
                    accepted_o <= STEP_W'(1);
                end
                MK_RESTART_EMPTY: begin
                    ack_o      <= 1'b0;
                    accepted_o <= '0;
                end
                default: begin
                    ack_o      <= ack_o;
                    accepted_o <= accepted_o;
                end
            endcase
        end
    end

    // Signal that the write in this cycle completes the order.
    always_comb begin
        seq_done_o = fire_i && (kind_i == MK_ADVANCE) && is_last_i;
    end

endmodule

// File: rtl/iso_pulse_timer.sv
// Waits EN_LAG cycles after start, then holds the enable for PULSE_LEN cycles.
// Assumes EN_LAG >= 1 and PULSE_LEN >= 1, and ignores start while busy.
module iso_pulse_timer
    import iso_unlock_pkg::*;
#(
    parameter int EN_LAG    = 16,
    parameter int PULSE_LEN = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic iso_en_o,
    output logic done_o
);

    localparam int CNT_MAX = (EN_LAG > PULSE_LEN) ? EN_LAG : PULSE_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LAG_LAST   = CNT_W'(EN_LAG - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_LEN - 1);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;

    // Step through collect, arm delay and pulse window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_COLLECT;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_COLLECT: begin
                    cnt_q <= '0;
                    if (start_i) phase_q <= PH_ARM;
                end
                PH_ARM: begin
                    if (cnt_q == LAG_LAST) begin
                        phase_q <= PH_PULSE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_PULSE: begin
                    if (cnt_q == PULSE_LAST) begin
                        phase_q <= PH_COLLECT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    phase_q <= PH_COLLECT;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Decode phase into busy, enable and completion flags.
    always_comb begin
        busy_o   = (phase_q != PH_COLLECT);
        iso_en_o = (phase_q == PH_PULSE);
        done_o   = (phase_q == PH_PULSE) && (cnt_q == PULSE_LAST);
    end

endmodule

// File: rtl/iso_unlock_seq.sv
// Top of the isolation unlock detector: matches the code order, toggles the
// acknowledge and drives the timed enable.
// Assumes one write strobe per bus write and that the consumer samples iso_en_o.
module iso_unlock_seq
    import iso_unlock_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int EN_LAG    = 16,
    parameter int PULSE_LEN = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en_i,
    input  logic [DATA_W-1:0] ctl_wr_data_i,
    output logic [DATA_W-1:0] ack_stat_o,
    output logic [DATA_W-1:0] iso_stat_o,
    output logic              iso_en_o
);

    localparam int ACK_POS = 3;
    localparam int EN_POS  = 0;

    logic [CODE_W-1:0] code;
    match_kind_t       kind;
    logic              is_last;
    logic              wr_fire;
    logic [STEP_W-1:0] accepted;
    logic              ack_bit;
    logic              seq_done;
    logic              busy;
    logic              pulse_done;
    logic              iso_en;

    // Extract the code field and qualify the write with timer idleness.
    always_comb begin
        code    = ctl_wr_data_i[CODE_W-1:0];
        wr_fire = ctl_wr_en_i && !busy;
    end

    iso_code_match u_match (
        .code_i     (code),
        .accepted_i (accepted),
        .kind_o     (kind),
        .is_last_o  (is_last)
    );

    iso_step_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (wr_fire),
        .kind_i     (kind),
        .is_last_i  (is_last),
        .clear_i    (pulse_done),
        .accepted_o (accepted),
        .ack_o      (ack_bit),
        .seq_done_o (seq_done)
    );

    iso_pulse_timer #(
        .EN_LAG    (EN_LAG),
        .PULSE_LEN (PULSE_LEN)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (seq_done),
        .busy_o   (busy),
        .iso_en_o (iso_en),
        .done_o   (pulse_done)
    );

    // Pack the acknowledge and enable bits into their status words.
    always_comb begin
        ack_stat_o          = '0;
        ack_stat_o[ACK_POS] = ack_bit;
        iso_stat_o          = '0;
        iso_stat_o[EN_POS]  = iso_en;
        iso_en_o            = iso_en;
    end

endmodule

// File: rtl/iso_unlock_chk.sv
// Property checker for the isolation unlock detector, bound to the top.
// Assumes it observes the matcher classification and the tracker/timer outputs.
module iso_unlock_chk
    import iso_unlock_pkg::*;
#(
    parameter int PULSE_LEN = 50000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_fire,
    input match_kind_t       kind,
    input logic [STEP_W-1:0] accepted,
    input logic              ack_bit,
    input logic              iso_en
);

    int run_q;

    // Count consecutive high cycles of the enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 0;
        else if (iso_en) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    assert_adv_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && kind == MK_ADVANCE) |=> (ack_bit == $past(accepted[0])));

    assert_restart_clears_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && (kind == MK_RESTART_FIRST || kind == MK_RESTART_EMPTY)) |=> !ack_bit);

    assert_hold_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && kind == MK_HOLD) |=> ($stable(accepted) && $stable(ack_bit)));

    assert_quiet_during_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iso_en |-> (!ack_bit && !wr_fire));

    assert_pulse_not_too_long_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iso_en |-> (run_q < PULSE_LEN));

    assert_pulse_full_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> (run_q == PULSE_LEN));

endmodule

bind iso_unlock_seq iso_unlock_chk #(
    .PULSE_LEN (PULSE_LEN)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .kind     (kind),
    .accepted (accepted),
    .ack_bit  (ack_bit),
    .iso_en   (iso_en)
);

// File: tb/iso_unlock_seq_tb.sv
module iso_unlock_seq_tb_top;

    localparam int LAG  = 5;
    localparam int PLEN = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ack_stat;
    logic [7:0] iso_stat;
    logic       iso_en;

    always #10 clk = ~clk;

    iso_unlock_seq #(.DATA_W(8), .EN_LAG(LAG), .PULSE_LEN(PLEN)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_wr_en_i   (wr_en),
        .ctl_wr_data_i (wr_data),
        .ack_stat_o    (ack_stat),
        .iso_stat_o    (iso_stat),
        .iso_en_o      (iso_en)
    );

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    int    pulses_seen = 0;
    bit    armed = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // Reference model state
    int m_n = 0, m_ack = 0, m_phase = 0, m_cnt = 0;

    function automatic int seqc(input int i);
        int tbl[7] = '{0, 1, 3, 7, 5, 1, 0};
        return tbl[i];
    endfunction

    // Behavioural model, updated on each rising edge from the driven inputs.
    always @(posedge clk) begin
        armed = 1;
        if (!rst_n) begin
            m_n = 0; m_ack = 0; m_phase = 0; m_cnt = 0;
        end else if (m_phase == 0) begin
            if (wr_en) begin
                int c;
                c = wr_data & 8'h07;
                if (m_n > 0 && c == seqc(m_n - 1)) begin
                    // repeat: nothing
                end else if (c == seqc(m_n)) begin
                    m_ack = m_n % 2;
                    m_n = m_n + 1;
                    if (m_n == 7) begin m_phase = 1; m_cnt = 0; end
                end else begin
                    m_ack = 0;
                    m_n = (c == 0) ? 1 : 0;
                end
            end
        end else if (m_phase == 1) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == LAG) begin m_phase = 2; m_cnt = 0; end
        end else begin
            m_cnt = m_cnt + 1;
            if (m_cnt == PLEN) begin m_phase = 0; m_n = 0; m_ack = 0; end
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (armed && !finished) begin
            logic [7:0] exp_ack, exp_iso;
            exp_ack = (m_ack != 0) ? 8'h08 : 8'h00;
            exp_iso = (m_phase == 2) ? 8'h01 : 8'h00;
            checks++;
            if (ack_stat !== exp_ack) begin
                fails++;
                $display("FAIL %s ack_stat actual %h expected %h", cur_req, ack_stat, exp_ack);
            end
            checks++;
            if (iso_stat !== exp_iso || iso_en !== exp_iso[0]) begin
                fails++;
                $display("FAIL %s/R7 iso_stat %h iso_en %b expected %h", cur_req, iso_stat, iso_en, exp_iso);
            end
            checks++;
            if ((ack_stat & 8'hF7) !== 8'h00 || (iso_stat & 8'hFE) !== 8'h00) begin
                fails++;
                $display("FAIL R10 spare bits ack %h iso %h expected 00", ack_stat, iso_stat);
            end
            if (iso_en === 1'b1 && m_phase == 2 && m_cnt == 0) pulses_seen++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual %0d cycles expected under 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    task automatic put(input logic [7:0] d, input logic en);
        wr_en = en;
        wr_data = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) put(8'h00, 1'b0);
    endtask

    task automatic wr(input logic [7:0] d, input int gap);
        put(d, 1'b1);
        idle(gap);
    endtask

    task automatic expect_pulses(input int want, input string req);
        checks++;
        if (pulses_seen != want) begin
            fails++;
            $display("FAIL %s pulse count actual %0d expected %0d", req, pulses_seen, want);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R4 / R3: full order back to back
        cur_req = "R4";
        wr(8'h00, 0); wr(8'h01, 0); wr(8'h03, 0); wr(8'h07, 0);
        wr(8'h05, 0); wr(8'h01, 0);
        cur_req = "R7";
        wr(8'h00, 0);
        idle(LAG + PLEN + 3);
        expect_pulses(1, "R7");

        // R9 / R2: a second sequence with upper data bits set, gaps of 2
        cur_req = "R2";
        wr(8'hA8, 2); wr(8'hF9, 2); wr(8'h5B, 2); wr(8'hFF, 2);
        wr(8'h0D, 2); wr(8'h89, 2);
        cur_req = "R9";
        wr(8'hF0, 1);
        // R8: writes during the delay and the pulse are ignored
        cur_req = "R8";
        wr(8'h03, 0); wr(8'h02, 0);
        idle(LAG);
        wr(8'h00, 2); wr(8'h01, 2); wr(8'h06, 2);
        idle(LAG + PLEN);
        expect_pulses(2, "R9");

        // R5: wrong codes restart, a stray 0 becomes step 0
        cur_req = "R5";
        wr(8'h00, 1); wr(8'h01, 1); wr(8'h03, 1); wr(8'h02, 1);
        wr(8'h01, 1);
        wr(8'h00, 1); wr(8'h01, 1); wr(8'h00, 1);
        wr(8'h01, 1); wr(8'h03, 1); wr(8'h07, 1); wr(8'h05, 1);
        wr(8'h01, 1); wr(8'h00, 1);
        idle(LAG + PLEN + 3);
        expect_pulses(3, "R5");

        // R6: repeats absorbed
        cur_req = "R6";
        wr(8'h00, 0); wr(8'h00, 0); wr(8'h01, 0); wr(8'h01, 1);
        wr(8'h01, 0); wr(8'h03, 0); wr(8'h07, 0); wr(8'h07, 0);
        wr(8'h05, 0); wr(8'h01, 0); wr(8'h01, 0); wr(8'h00, 0);
        idle(LAG + PLEN + 3);
        expect_pulses(4, "R6");

        // R1: reset in the middle of a sequence
        cur_req = "R1";
        wr(8'h00, 0); wr(8'h01, 0); wr(8'h03, 0);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        wr(8'h07, 0); wr(8'h05, 0); wr(8'h01, 0); wr(8'h00, 0);
        idle(LAG + PLEN + 3);
        expect_pulses(4, "R1");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule